// File: doc/BRIEF.md
# Sprite Page Copy Engine with Sample-Fetch Stall Arbitration

This block moves one 256-byte page of CPU address space into a 256-entry sprite memory while the CPU is held off the bus. A CPU write to the trigger port names the source page. The engine first spends one or two idle alignment cycles, depending on the parity of the current CPU cycle. It then alternates a bus read cycle and a sprite-memory write cycle for each of the 256 bytes. The destination index starts at the sprite address present at the trigger and wraps modulo 256.

A second requester, the audio sample fetcher, can ask for bus time at any moment. Each accepted request stalls the CPU for a fixed number of cycles: four when no page copy is running, and two while the copy is active. The copy counts as active from the trigger until the write of byte 0xFE. A two-cycle stall that is still at its first cycle when the copy flag drops is cut to a single cycle. When a stall ends, the engine pulses a buffer-load strobe to the sample channel. The CPU halt output covers both the copy and any stall. The cycle parity comes from an external free-running cycle counter.

Top module: `spr_dma_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no stimulus, `cpu_halt`, `bus_rd`, `spr_we`, `smp_ack` and `smp_load` are all 0.
- R2: After a trigger write accepted on a clock edge, `cpu_halt` rises in the next cycle. That cycle is idle, and one more idle cycle follows when `cyc_odd` was 1 at the trigger edge, before the first read.
- R3: The copy issues exactly 256 reads. Read i drives `bus_addr` = {page, i} with i rising from 0 to 255, and every read cycle is followed directly by one write cycle.
- R4: Byte i is written to sprite index (sprite address sampled at the trigger + i) mod 256, with the value returned by read i.
- R5: `cpu_halt` stays high for 513 consecutive cycles for a copy started at even parity and 514 for odd parity, when no sample stall extends it.
- R6: A trigger write while a copy is in progress is ignored: source page, byte count and duration are unchanged.
- R7: A sample request with no copy running is acknowledged in the same cycle, holds `cpu_halt` for the 4 following cycles, and `smp_load` pulses for one cycle in the cycle after the stall.
- R8: A sample request accepted while the copy is active (from the trigger until the write of byte 0xFE) stalls for 2 cycles, with `smp_load` 3 cycles after the acknowledge cycle.
- R9: A sample request acknowledged in the read cycle of byte 0xFE has its stall shortened to 1 cycle, so `smp_load` comes 2 cycles after the acknowledge cycle.
- R10: `cpu_halt` stays high until both the last sprite write and any sample stall are finished. A request acknowledged in the read cycle of byte 0xFF gets a 4-cycle stall and stretches an even-start copy's halt to 516 cycles.
- R11: A sample request while a stall is already counting is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Trigger register write strobe |
| trig_page | input | 8 | Source page number carried by the trigger write |
| spr_addr | input | 8 | Current sprite address register value |
| cyc_odd | input | 1 | Parity of the CPU cycle counter |
| bus_addr | output | 16 | CPU bus address during copy reads |
| bus_rd | output | 1 | CPU bus read strobe |
| bus_rdata | input | 8 | CPU bus read data, valid in the read cycle |
| spr_we | output | 1 | Sprite memory write enable |
| spr_waddr | output | 8 | Sprite memory write index |
| spr_wdata | output | 8 | Sprite memory write data |
| smp_req | input | 1 | Sample fetch request |
| smp_ack | output | 1 | Sample request accepted this cycle |
| smp_load | output | 1 | One-cycle buffer-load strobe at the end of a stall |
| cpu_halt | output | 1 | Holds the CPU off the bus |

## Verification
The bench sets inputs on the falling edge and samples one time unit later, so every check sees the cycle state left by the previous rising edge. It numbers cycles from the one after the trigger edge. The halt is due in cycle 0, the first read in cycle 1 or 2 by parity, and the halt falls in cycle 513, 514 or 516. Sample acknowledges are read in the same cycle as the request, and `smp_load` is expected 5, 3, 2 or 5 cycles after the acknowledge, depending on whether the copy is idle, active, ending at byte 0xFE or finished. Sprite contents are compared after the halt drops, against a data pattern the bench computes from the address.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT1,
    SQ_WAIT2,
    SQ_READ,
    SQ_WRITE
  } seq_st_e;
endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_we,
  input  logic [PAGE_W-1:0]       trig_page,
  input  logic [IDX_W-1:0]        spr_base,
  input  logic                    cyc_odd,
  output logic [PAGE_W+IDX_W-1:0] bus_addr,
  output logic                    bus_rd,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    spr_we,
  output logic [IDX_W-1:0]        spr_waddr,
  output logic [DATA_W-1:0]       spr_wdata,
  output logic                    busy,
  output logic                    copy_act,
  output logic                    copy_drop
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] DROP_IDX = LAST_IDX - IDX_W'(1);

  seq_st_e            st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [IDX_W-1:0]   base_q, base_d;
  logic               odd_q, odd_d;
  logic [DATA_W-1:0]  data_q;
  logic               data_en;
  logic               drop_q, drop_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    page_d    = page_q;
    base_d    = base_q;
    odd_d     = odd_q;
    drop_d    = drop_q;
    copy_drop = 1'b0;
    data_en   = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (trig_we) begin
          st_d   = SQ_WAIT1;
          page_d = trig_page;
          base_d = spr_base;
          odd_d  = cyc_odd;
          idx_d  = '0;
          drop_d = 1'b0;
        end
      end
      SQ_WAIT1: st_d = odd_q ? SQ_WAIT2 : SQ_READ;
      SQ_WAIT2: st_d = SQ_READ;
      SQ_READ: begin
        data_en = 1'b1;
        st_d    = SQ_WRITE;
      end
      SQ_WRITE: begin
        if (idx_q == DROP_IDX) begin
          drop_d    = 1'b1;
          copy_drop = 1'b1;
        end
        if (idx_q == LAST_IDX) begin
          st_d = SQ_IDLE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = SQ_READ;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      page_q <= '0;
      base_q <= '0;
      odd_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      page_q <= page_d;
      base_q <= base_d;
      odd_q  <= odd_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= bus_rdata;
    end
  end

  assign bus_rd    = (st_q == SQ_READ);
  assign bus_addr  = {page_q, idx_q};
  assign spr_we    = (st_q == SQ_WRITE);
  assign spr_waddr = base_q + idx_q;
  assign spr_wdata = data_q;
  assign busy      = (st_q != SQ_IDLE);
  assign copy_act  = busy && !drop_q;
endmodule

// File: rtl/spr_dma_smp.sv
module spr_dma_smp #(
  parameter int CNT_W      = 3,
  parameter int LEN_FULL   = 4,
  parameter int LEN_SHORT  = 2,
  parameter int CUT_AT     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic copy_act,
  input  logic copy_drop,
  output logic ack,
  output logic stall,
  output logic load
);
  localparam logic [CNT_W-1:0] FULL_V  = CNT_W'(LEN_FULL);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(LEN_SHORT);
  localparam logic [CNT_W-1:0] CUT_V   = CNT_W'(CUT_AT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_q, load_d;

  always_comb begin
    cnt_d = cnt_q;
    ack   = req && (cnt_q == '0);
    if (cnt_q == '0) begin
      if (req) cnt_d = copy_act ? SHORT_V : FULL_V;
    end else if (copy_drop && (cnt_q == CUT_V)) begin
      cnt_d = cnt_q - CNT_W'(2);
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    load_d = (cnt_q != '0) && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
    end
  end

  assign stall = (cnt_q != '0);
  assign load  = load_q;
endmodule

// File: rtl/spr_dma_ctrl.sv
module spr_dma_ctrl #(
  parameter int PAGE_W      = 8,
  parameter int IDX_W       = 8,
  parameter int DATA_W      = 8,
  parameter int STALL_CNT_W = 3,
  parameter int STALL_FULL  = 4,
  parameter int STALL_SHORT = 2,
  localparam int ADDR_W     = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  input  logic [IDX_W-1:0]  spr_addr,
  input  logic              cyc_odd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              spr_we,
  output logic [IDX_W-1:0]  spr_waddr,
  output logic [DATA_W-1:0] spr_wdata,
  input  logic              smp_req,
  output logic              smp_ack,
  output logic              smp_load,
  output logic              cpu_halt
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       seq_busy, copy_act, copy_drop, smp_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  spr_dma_seq #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .trig_we   (trig_we),
    .trig_page (trig_page),
    .spr_base  (spr_addr),
    .cyc_odd   (cyc_odd),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .spr_we    (spr_we),
    .spr_waddr (spr_waddr),
    .spr_wdata (spr_wdata),
    .busy      (seq_busy),
    .copy_act  (copy_act),
    .copy_drop (copy_drop)
  );

  spr_dma_smp #(.CNT_W(STALL_CNT_W), .LEN_FULL(STALL_FULL),
                .LEN_SHORT(STALL_SHORT), .CUT_AT(STALL_SHORT)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req       (smp_req),
    .copy_act  (copy_act),
    .copy_drop (copy_drop),
    .ack       (smp_ack),
    .stall     (smp_stall),
    .load      (smp_load)
  );

  assign cpu_halt = seq_busy | smp_stall;
endmodule

// File: rtl/spr_dma_ctrl_chk.sv
module spr_dma_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              spr_we,
  input logic [IDX_W-1:0]  spr_waddr,
  input logic [DATA_W-1:0] spr_wdata,
  input logic              smp_ack,
  input logic              smp_load,
  input logic              cpu_halt
);
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> spr_we); // R3
  AST_RD_NOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !spr_we); // R3
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(spr_we) && $past(bus_rd, 2)) |-> bus_addr == $past(bus_addr, 2) + ADDR_W'(1)); // R3
  AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |-> spr_wdata == $past(bus_rdata)); // R4
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && $past(bus_rd) && $past(spr_we, 2)) |-> spr_waddr == $past(spr_waddr, 2) + IDX_W'(1)); // R4
  AST_HALT_COVERS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || spr_we) |-> cpu_halt); // R5
  AST_ACK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ack |=> cpu_halt); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_load |=> !smp_load); // R7
  AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ack |=> !smp_ack); // R11
endmodule

bind spr_dma_ctrl spr_dma_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .spr_we    (spr_we),
  .spr_waddr (spr_waddr),
  .spr_wdata (spr_wdata),
  .smp_ack   (smp_ack),
  .smp_load  (smp_load),
  .cpu_halt  (cpu_halt)
);

// File: tb/spr_dma_ctrl_tb.sv
module spr_dma_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_we;
  logic [7:0]  trig_page;
  logic [7:0]  spr_addr;
  logic        cyc_odd;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        spr_we;
  logic [7:0]  spr_waddr;
  logic [7:0]  spr_wdata;
  logic        smp_req;
  logic        smp_ack;
  logic        smp_load;
  logic        cpu_halt;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] cyc = 0;
  logic [7:0]  spr_mem [256];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign cyc_odd = cyc[0];

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  always @(posedge clk) if (spr_we) spr_mem[spr_waddr] <= spr_wdata;

  spr_dma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_page(trig_page),
    .spr_addr(spr_addr), .cyc_odd(cyc_odd), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .spr_we(spr_we), .spr_waddr(spr_waddr),
    .spr_wdata(spr_wdata), .smp_req(smp_req), .smp_ack(smp_ack),
    .smp_load(smp_load), .cpu_halt(cpu_halt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // smp_mode: 0 none, 1 mid-copy, 2 at read of 0xFE, 3 at read of 0xFF
  task automatic run_copy(input logic [7:0] page, input logic [7:0] base, input bit odd,
                          input bit retrig, input int smp_mode,
                          output int halt_n, output int first_rd, output int nrd,
                          output int rd_bad, output int ack_ok, output int load_dly,
                          output int mem_bad);
    int ack_n = -1;
    int load_n = -1;
    bit done = 0;
    halt_n = 0; first_rd = -1; nrd = 0; rd_bad = 0; ack_ok = 0; load_dly = -1; mem_bad = 0;
    for (int i = 0; i < 256; i++) spr_mem[i] = 8'hEE;
    @(negedge clk);
    while (cyc[0] != odd) @(negedge clk);
    trig_we = 1'b1; trig_page = page; spr_addr = base;
    for (int n = 0; n < 1000 && !done; n++) begin
      @(negedge clk);
      trig_we = 1'b0; smp_req = 1'b0; spr_addr = ~base;
      #1;
      if (smp_load && load_n < 0) load_n = n;
      if (!cpu_halt) begin
        halt_n = n; done = 1;
      end else begin
        if (bus_rd) begin
          if (first_rd < 0) first_rd = n;
          if (bus_addr != {page, nrd[7:0]}) rd_bad++;
          nrd++;
        end
        if (retrig && n == 50) begin trig_we = 1'b1; trig_page = ~page; end
        if ((smp_mode == 1 && n == 100) ||
            (smp_mode == 2 && bus_rd && bus_addr[7:0] == 8'hFE) ||
            (smp_mode == 3 && bus_rd && bus_addr[7:0] == 8'hFF)) begin
          smp_req = 1'b1; #1; ack_ok = smp_ack; ack_n = n;
        end
      end
    end
    for (int n = halt_n + 1; n < halt_n + 4; n++) begin
      @(negedge clk); #1;
      if (smp_load && load_n < 0) load_n = n;
    end
    if (ack_n >= 0 && load_n >= 0) load_dly = load_n - ack_n;
    for (int i = 0; i < 256; i++)
      if (spr_mem[(base + i) & 8'hFF] != mem_val({page, i[7:0]})) mem_bad++;
  endtask

  task automatic t_reset();
    chk("R1 halt", cpu_halt, 0); chk("R1 bus_rd", bus_rd, 0);
    chk("R1 spr_we", spr_we, 0); chk("R1 smp_ack", smp_ack, 0);
    chk("R1 smp_load", smp_load, 0);
  endtask

  task automatic t_copy_even();
    int h, f, n, b, a, d, m;
    run_copy(8'h12, 8'h00, 0, 0, 0, h, f, n, b, a, d, m);
    chk("R2 first read even", f, 1);
    chk("R3 read count", n, 256);
    chk("R3 read addresses", b, 0);
    chk("R4 sprite contents", m, 0);
    chk("R5 halt even", h, 513);
  endtask

  task automatic t_copy_odd_wrap();
    int h, f, n, b, a, d, m;
    run_copy(8'h80, 8'hF0, 1, 0, 0, h, f, n, b, a, d, m);
    chk("R2 first read odd", f, 2);
    chk("R4 wrap contents", m, 0);
    chk("R5 halt odd", h, 514);
  endtask

  task automatic t_retrigger();
    int h, f, n, b, a, d, m;
    run_copy(8'h33, 8'h05, 0, 1, 0, h, f, n, b, a, d, m);
    chk("R6 reads unchanged page", b, 0);
    chk("R6 read count", n, 256);
    chk("R6 halt length", h, 513);
    chk("R6 contents", m, 0);
  endtask

  task automatic t_smp_idle();
    int halt_cnt = 0;
    int load_at = -1;
    @(negedge clk);
    smp_req = 1'b1; #1;
    chk("R7 ack idle", smp_ack, 1);
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk); smp_req = 1'b0; #1;
      if (cpu_halt) halt_cnt++;
      if (smp_load && load_at < 0) load_at = n;
      if (n == 2) begin
        smp_req = 1'b1; #1;
        chk("R11 no ack while stalled", smp_ack, 0);
      end
    end
    chk("R7 stall length", halt_cnt, 4);
    chk("R7 load timing", load_at, 5);
  endtask

  task automatic t_smp_mid();
    int h, f, n, b, a, d, m;
    run_copy(8'h44, 8'h10, 0, 0, 1, h, f, n, b, a, d, m);
    chk("R8 ack in copy", a, 1);
    chk("R8 load delay", d, 3);
    chk("R8 halt", h, 513);
  endtask

  task automatic t_smp_fe();
    int h, f, n, b, a, d, m;
    run_copy(8'h55, 8'h00, 0, 0, 2, h, f, n, b, a, d, m);
    chk("R9 ack at FE", a, 1);
    chk("R9 load delay", d, 2);
    chk("R9 halt", h, 513);
  endtask

  task automatic t_smp_ff();
    int h, f, n, b, a, d, m;
    run_copy(8'h66, 8'h00, 0, 0, 3, h, f, n, b, a, d, m);
    chk("R10 ack at FF", a, 1);
    chk("R10 load delay", d, 5);
    chk("R10 halt extended", h, 516);
    chk("R10 contents", m, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_we = 1'b0; trig_page = 8'h00; spr_addr = 8'h00; smp_req = 1'b0;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 t_reset();
    t_copy_even();
    t_copy_odd_wrap();
    t_retrigger();
    t_smp_idle();
    t_smp_mid();
    t_smp_fe();
    t_smp_ff();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule